// File: doc/BRIEF.md
# Console CPU address decoder

This block sits between an 8-bit console processor and its memories. It takes a 16-bit address with read and write strobes and steers each access to one of three targets: a 2 KB work RAM, a 24-byte I/O register file, or cartridge space. The RAM and the register file are held inside the block as synchronous byte arrays. The cartridge program ROM is a byte array that is filled through a separate load port before the processor runs. Each target gets a chip select and its own local index. Read data comes back through a registered multiplexer one cycle after the request.

The RAM answers at every address from 0x0000 to 0x1FFF but decodes only the low 11 bits, so the 2 KB array shows up four times. The I/O file answers at 0x4000 through 0x4017. Everything from 0x4020 upward belongs to the cartridge. Within that space, the program ROM window at 0x8000 to 0xFFFF is indexed by the low 14 bits, so a 16 KB image answers at both 0x8000 and 0xC000. The ROM store holds 2^ROM_AW bytes. When ROM_AW is below 14, the store repeats inside that 16 KB index. Two ranges select nothing: 0x2000 to 0x3FFF and 0x4018 to 0x401F.

A two-state controller sequences the block. After reset it is in ST_CLEAR, where it writes zero to one RAM location per cycle, and to the matching I/O location while the index is below 24. It also holds `ready` low and ignores the processor strobes. The transition to ST_READY happens on the cycle the sweep index reaches the last RAM location. ST_READY then holds until the next reset.

Top module: `cpu_addr_decoder`

## Requirements
- R1: After reset `ready` stays low for 2^11 cycles while RAM and I/O are cleared, and no select or response is given. Once `ready` rises it stays high, and every RAM and I/O byte reads 0x00.
- R2: An access at 0x0000–0x1FFF asserts `ram_cs` with `ram_idx` = addr[10:0]. Addresses that differ only in bits 12:11 reach the same byte.
- R3: An access at 0x4000–0x4017 asserts `io_cs` with `io_idx` = addr − 0x4000. The byte written there reads back unchanged.
- R4: An access at 0x4020–0xFFFF asserts `cart_cs`.
- R5: At 0x8000–0xFFFF, `rom_idx` = addr AND 0x3FFF, so 0x8000+n and 0xC000+n return the same ROM byte.
- R6: Accesses at 0x2000–0x3FFF and 0x4018–0x401F assert no select. Reads there return 0x00, and writes there change no RAM or I/O byte.
- R7: A processor write inside 0x8000–0xFFFF leaves the ROM unchanged. Reads at 0x4020–0x7FFF return 0x00.
- R8: `rvalid` is high exactly one cycle after a read strobe accepted while ready, and `rdata` carries that read's byte. At most one select is high, and none is high without a strobe.
- R9: While `rom_ld_en` is high, the ROM byte at `rom_ld_addr` takes `rom_ld_data`. ROM reads use `rom_idx` modulo 2^ROM_AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rom_ld_en | input | 1 | ROM preload write enable |
| rom_ld_addr | input | ROM_AW | ROM preload index |
| rom_ld_data | input | 8 | ROM preload byte |
| ready | output | 1 | High once the clear sweep is done |
| ram_cs | output | 1 | Work RAM select |
| io_cs | output | 1 | I/O register file select |
| cart_cs | output | 1 | Cartridge space select |
| ram_idx | output | 11 | Local RAM index |
| io_idx | output | 5 | Local I/O index |
| rom_idx | output | 14 | Local program ROM index |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions check several properties on every cycle:
- the selects never overlap;
- each select appears only inside its own address window;
- the two holes never raise a select and always read zero;
- `rvalid` follows an accepted read by exactly one cycle;
- nothing is selected during ST_CLEAR, and `ready` never falls.

Only the bench scenarios can show that data lands in the right byte. Those scenarios cover:
- the RAM mirrors aliasing;
- the clear sweep leaving zeros;
- ROM bytes repeating at 0x8000 and 0xC000;
- writes to holes and to the ROM window leaving stored contents unchanged.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int RAM_AW    = 11;
    localparam int IO_DEPTH  = 24;
    localparam int IO_AW     = $clog2(IO_DEPTH);
    localparam int ROM_IDX_W = 14;

    localparam logic [ADDR_W-1:0] RAM_TOP   = 16'h1FFF;
    localparam logic [ADDR_W-1:0] IO_BASE   = 16'h4000;
    localparam logic [ADDR_W-1:0] IO_TOP    = 16'h4017;
    localparam logic [ADDR_W-1:0] CART_BASE = 16'h4020;
    localparam logic [ADDR_W-1:0] ROM_BASE  = 16'h8000;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_RAM,
        RG_IO,
        RG_ROM,
        RG_CART_LO
    } region_e;

    typedef enum logic {
        ST_CLEAR,
        ST_READY
    } dec_state_e;
endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
    import addr_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr <= RAM_TOP)
            region = RG_RAM;
        else if (addr >= IO_BASE && addr <= IO_TOP)
            region = RG_IO;
        else if (addr >= ROM_BASE)
            region = RG_ROM;
        else if (addr >= CART_BASE)
            region = RG_CART_LO;
        else
            region = RG_NONE;
    end
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (32'(waddr) < DEPTH))
            mem[waddr] <= wdata;
        if (32'(raddr) < DEPTH)
            rdata <= mem[raddr];
        else
            rdata <= '0;
    end
endmodule

// File: rtl/cpu_addr_decoder.sv
module cpu_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int ROM_AW = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic                 rom_ld_en,
    input  logic [ROM_AW-1:0]    rom_ld_addr,
    input  logic [DATA_W-1:0]    rom_ld_data,
    output logic                 ready,
    output logic                 ram_cs,
    output logic                 io_cs,
    output logic                 cart_cs,
    output logic [RAM_AW-1:0]    ram_idx,
    output logic [IO_AW-1:0]     io_idx,
    output logic [ROM_IDX_W-1:0] rom_idx,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rvalid
);
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int ROM_DEPTH = 1 << ROM_AW;
    localparam logic [RAM_AW-1:0] SWEEP_LAST = RAM_AW'(RAM_DEPTH - 1);
    localparam logic [RAM_AW-1:0] IO_LIMIT   = RAM_AW'(IO_DEPTH);

    dec_state_e        state;
    logic [RAM_AW-1:0] clr_idx;
    region_e           region;
    region_e           rd_region;
    logic              clearing;
    logic              access;

    logic              ram_we, io_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic [IO_AW-1:0]  io_waddr;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] ram_q, io_q, rom_q;

    addr_region_decode u_decode (
        .addr   (addr),
        .region (region)
    );

    // State register: clear sweep, then serve accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_CLEAR;
            clr_idx <= '0;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    clr_idx <= clr_idx + 1'b1;
                    if (clr_idx == SWEEP_LAST)
                        state <= ST_READY;
                end
                ST_READY: state <= ST_READY;
            endcase
        end
    end

    // Outputs and store controls derived from the state.
    always_comb begin
        clearing = 1'b0;
        ready    = 1'b0;
        unique case (state)
            ST_CLEAR: clearing = 1'b1;
            ST_READY: ready    = 1'b1;
        endcase

        access  = ready && (rd_en || wr_en);
        ram_cs  = access && (region == RG_RAM);
        io_cs   = access && (region == RG_IO);
        cart_cs = access && ((region == RG_ROM) || (region == RG_CART_LO));

        ram_idx = addr[RAM_AW-1:0];
        io_idx  = addr[IO_AW-1:0];
        rom_idx = addr[ROM_IDX_W-1:0];

        ram_we    = clearing || (ready && wr_en && (region == RG_RAM));
        io_we     = clearing ? (clr_idx < IO_LIMIT)
                             : (ready && wr_en && (region == RG_IO));
        ram_waddr = clearing ? clr_idx : ram_idx;
        io_waddr  = clearing ? clr_idx[IO_AW-1:0] : io_idx;
        st_wdata  = clearing ? '0 : wdata;
    end

    byte_store #(.DEPTH(RAM_DEPTH), .AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (st_wdata),
        .raddr (ram_idx),
        .rdata (ram_q)
    );

    byte_store #(.DEPTH(IO_DEPTH), .AW(IO_AW), .DW(DATA_W)) u_io (
        .clk   (clk),
        .we    (io_we),
        .waddr (io_waddr),
        .wdata (st_wdata),
        .raddr (io_idx),
        .rdata (io_q)
    );

    byte_store #(.DEPTH(ROM_DEPTH), .AW(ROM_AW), .DW(DATA_W)) u_rom (
        .clk   (clk),
        .we    (rom_ld_en),
        .waddr (rom_ld_addr),
        .wdata (rom_ld_data),
        .raddr (rom_idx[ROM_AW-1:0]),
        .rdata (rom_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid    <= 1'b0;
            rd_region <= RG_NONE;
        end else begin
            rvalid    <= ready && rd_en;
            rd_region <= (ready && rd_en) ? region : RG_NONE;
        end
    end

    always_comb begin
        unique case (rd_region)
            RG_RAM:  rdata = ram_q;
            RG_IO:   rdata = io_q;
            RG_ROM:  rdata = rom_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/addr_dec_checker.sv
module addr_dec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic        ready,
    input logic        ram_cs,
    input logic        io_cs,
    input logic        cart_cs,
    input logic [7:0]  rdata,
    input logic        rvalid
);
    logic in_hole;
    assign in_hole = (addr >= 16'h2000 && addr <= 16'h3FFF) ||
                     (addr >= 16'h4018 && addr <= 16'h401F);

    p_cs_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, io_cs, cart_cs}));

    p_cs_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> !(ram_cs || io_cs || cart_cs));

    p_ram_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs |-> addr <= 16'h1FFF);

    p_io_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        io_cs |-> (addr >= 16'h4000 && addr <= 16'h4017));

    p_cart_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cart_cs |-> addr >= 16'h4020);

    p_hole_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_hole |-> !(ram_cs || io_cs || cart_cs));

    p_hole_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready && in_hole) |=> (rvalid && rdata == 8'h00));

    p_rvalid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en && ready));

    p_read_answered_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ready) |=> rvalid);

    p_quiet_while_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !(ram_cs || io_cs || cart_cs));

    p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
endmodule

bind cpu_addr_decoder addr_dec_checker u_addr_dec_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .ready   (ready),
    .ram_cs  (ram_cs),
    .io_cs   (io_cs),
    .cart_cs (cart_cs),
    .rdata   (rdata),
    .rvalid  (rvalid)
);

// File: tb/cpu_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module cpu_addr_decoder_tb_top;
    localparam int ROM_AW = 11;
    localparam int ROM_DEPTH = 1 << ROM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       addr = '0;
    logic [7:0]        wdata = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic              rom_ld_en = 1'b0;
    logic [ROM_AW-1:0] rom_ld_addr = '0;
    logic [7:0]        rom_ld_data = '0;
    logic              ready, ram_cs, io_cs, cart_cs, rvalid;
    logic [10:0]       ram_idx;
    logic [4:0]        io_idx;
    logic [13:0]       rom_idx;
    logic [7:0]        rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #4 clk = ~clk;

    cpu_addr_decoder #(.ROM_AW(ROM_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .rom_ld_en(rom_ld_en),
        .rom_ld_addr(rom_ld_addr), .rom_ld_data(rom_ld_data),
        .ready(ready), .ram_cs(ram_cs), .io_cs(io_cs), .cart_cs(cart_cs),
        .ram_idx(ram_idx), .io_idx(io_idx), .rom_idx(rom_idx),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && rvalid && !finished) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8: actual unexpected rvalid expected none");
            end else begin
                check(tag_q.pop_front(), {8'h00, rdata}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    // sel = {ram, io, cart}
    task automatic do_read(input logic [15:0] a, input logic [7:0] exp,
                           input logic [2:0] sel, input string tag);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        #1;
        check({tag, " select"}, {13'b0, ram_cs, io_cs, cart_cs}, {13'b0, sel});
        if (sel[2]) check("R2 ram_idx", {5'b0, ram_idx}, {5'b0, a[10:0]});
        if (sel[1]) check("R3 io_idx", {11'b0, io_idx}, a - 16'h4000);
        if (a >= 16'h8000) check("R5 rom_idx", {2'b0, rom_idx}, a & 16'h3FFF);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rom_load(input int idx, input logic [7:0] d);
        @(negedge clk);
        rom_ld_en   = 1'b1;
        rom_ld_addr = ROM_AW'(idx);
        rom_ld_data = d;
        @(negedge clk);
        rom_ld_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int wait_cnt;
        repeat (3) @(negedge clk);
        check("R1 ready in reset", {15'b0, ready}, 16'h0);
        check("R1 rvalid in reset", {15'b0, rvalid}, 16'h0);
        rom_load(5, 8'hA5);
        rom_load(ROM_DEPTH - 1, 8'h3C);
        rst_n = 1'b1;
        @(negedge clk);
        rd_en = 1'b1;
        addr  = 16'h0010;
        #1;
        check("R1 ready low during clear", {15'b0, ready}, 16'h0);
        check("R1 no select during clear", {13'b0, ram_cs, io_cs, cart_cs}, 16'h0);
        @(negedge clk);
        rd_en = 1'b0;
        check("R1 no response during clear", {15'b0, rvalid}, 16'h0);
        wait_cnt = 0;
        while (!ready && wait_cnt < 5000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check("R1 ready after sweep", {15'b0, ready}, 16'h1);
        check("R1 sweep length", 16'(wait_cnt >= 2000 && wait_cnt <= 2100), 16'h1);

        // R1: cleared contents
        do_read(16'h0010, 8'h00, 3'b100, "R1 ram cleared");
        do_read(16'h07FF, 8'h00, 3'b100, "R1 ram top cleared");
        do_read(16'h4003, 8'h00, 3'b010, "R1 io cleared");

        // R8: idle gives no select
        @(negedge clk);
        addr = 16'h0000;
        #1;
        check("R8 idle no select", {13'b0, ram_cs, io_cs, cart_cs}, 16'h0);

        // R2: mirrors
        do_write(16'h0123, 8'h5A);
        do_read(16'h0923, 8'h5A, 3'b100, "R2 mirror 1");
        do_read(16'h1123, 8'h5A, 3'b100, "R2 mirror 2");
        do_read(16'h1923, 8'h5A, 3'b100, "R2 mirror 3");
        do_write(16'h1FFF, 8'hC3);
        do_read(16'h07FF, 8'hC3, 3'b100, "R2 top mirror");

        // R3: I/O file
        do_write(16'h4000, 8'h11);
        do_write(16'h4017, 8'h77);
        do_read(16'h4000, 8'h11, 3'b010, "R3 io first");
        do_read(16'h4017, 8'h77, 3'b010, "R3 io last");

        // R6: holes
        do_write(16'h2123, 8'hFF);
        do_read(16'h0123, 8'h5A, 3'b100, "R6 hole write left ram");
        do_read(16'h2123, 8'h00, 3'b000, "R6 hole read low");
        do_read(16'h3FFF, 8'h00, 3'b000, "R6 hole read high");
        do_write(16'h4018, 8'h99);
        do_read(16'h4018, 8'h00, 3'b000, "R6 io gap read");
        do_read(16'h4000, 8'h11, 3'b010, "R6 io gap write left io");
        do_read(16'h401F, 8'h00, 3'b000, "R6 io gap end");

        // R4 / R7: lower cartridge space
        do_read(16'h4020, 8'h00, 3'b001, "R4 cart base R7 zero");
        do_read(16'h5000, 8'h00, 3'b001, "R7 cart low zero");

        // R5 / R9: ROM window
        do_read(16'h8005, 8'hA5, 3'b001, "R5 rom low half");
        do_read(16'hC005, 8'hA5, 3'b001, "R5 rom high half");
        do_read(16'h8000 | 16'(ROM_DEPTH + 5), 8'hA5, 3'b001, "R9 store repeat");
        do_read(16'hBFFF, 8'h3C, 3'b001, "R9 store last");

        // R7: ROM not writable by processor
        do_write(16'h8005, 8'h00);
        do_read(16'h8005, 8'hA5, 3'b001, "R7 rom write ignored");

        // R8: back-to-back reads keep order
        do_read(16'h4017, 8'h77, 3'b010, "R8 b2b first");
        do_read(16'h0923, 8'h5A, 3'b100, "R8 b2b second");

        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 16'(exp_q.size()), 16'h0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule